// File: doc/BRIEF.md
# Two-Delta Stride Value Predictor

This block forecasts the next result that a static instruction will produce. It keeps a direct-mapped, untagged table that is indexed by low bits of the instruction address. Each entry holds four things: the last value that was seen, a recent stride, a stable stride and a small confidence counter. A lookup returns the last value plus the stable stride. It also returns a flag that says whether the prediction is worth using.

When the instruction's real result is known, it arrives on the update port. The block then forms the new difference against the stored value. It always records that difference as the recent stride. The stable stride is replaced only when the same difference has been seen twice in a row, so a single irregular value does not disturb a settled stride. Whether the old prediction matched the real result moves the saturating counter up or down. Constant sequences fall out as stride zero. Strict arithmetic sequences are predicted exactly once the stride has repeated.

Top module: `stride_value_predictor`

## Requirements
- R1: After reset every entry is invalid. A lookup of an invalid entry returns value 0 with lkpConfident low.
- R2: The first update of an invalid entry stores the value, clears both strides and sets the counter to 0. A later lookup of that entry returns the stored value with lkpConfident low.
- R3: A lookup of a valid entry returns the stored last value plus the stable stride, taken modulo 2^32.
- R4: Every update of a valid entry sets the recent stride to (new value - stored last value) mod 2^32, computed before the last value is overwritten. The stable stride takes that difference only when it equals the recent stride held before this update; otherwise the stable stride keeps its value.
- R5: A constant sequence is predicted as that constant from its second update onward.
- R6: A strict arithmetic sequence, including one that wraps past 2^32, is predicted exactly from its third update onward.
- R7: The 2-bit counter of a valid entry increments (saturating at 3) when the prediction held before the update equals the new value, and decrements (saturating at 0) otherwise. lkpConfident is high when the entry is valid and its counter is 2 or 3.
- R8: The table has 64 entries. The index is address bits [7:2], and the other address bits are ignored, so two addresses that differ only outside [7:2] share an entry.
- R9: A lookup in the same cycle as an update sees the state from before that update. The update becomes visible to lookups from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| lkpPc | input | 32 | Instruction address to predict for |
| lkpValue | output | 32 | Predicted result (combinational from table state) |
| lkpConfident | output | 1 | Prediction is trusted |
| updValid | input | 1 | Update strobe |
| updPc | input | 32 | Instruction address of the resolved result |
| updValue | input | 32 | Real result of the instruction |

## Verification
The assertions assume that updValid, updPc and updValue are known and steady around each rising edge. They also assume that reset is held for at least one edge before the first update, so that every entry starts invalid. The bench changes all inputs only on the falling edge and keeps updValid low during reset. Its random traffic uses a handful of addresses, two of which alias to the same entry. The value streams mix steady strides, occasional stride changes and random outliers, so the counter is driven both up and down and the stable stride is made to hold as well as switch.

// File: rtl/svp_pkg.sv
package svp_pkg;

  // Strobes from control to datapath for one update
  typedef struct packed {
    logic wrEn;        // write the addressed entry
    logic init;        // first touch: load value, clear strides and counter
    logic takeStride;  // promote new difference into the stable stride
    logic cntUp;       // saturating counter increment
    logic cntDown;     // saturating counter decrement
  } svp_strobe_t;

endpackage

// File: rtl/svp_ctrl.sv
module svp_ctrl #(
  parameter int CNT_W = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  updValid,
  input  logic                  entryValid,
  input  logic                  predHit,
  input  logic                  strideRepeat,
  input  logic [CNT_W-1:0]      entryCnt,
  output svp_pkg::svp_strobe_t  strobe
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic trained;
  assign trained = updValid && entryValid;

  always_comb begin
    strobe            = '0;
    strobe.wrEn       = updValid;
    strobe.init       = updValid && !entryValid;
    strobe.takeStride = trained && strideRepeat;
    strobe.cntUp      = trained && predHit && (entryCnt != CNT_MAX);
    strobe.cntDown    = trained && !predHit && (entryCnt != '0);
  end

  // R7
  cnt_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.cntUp, strobe.cntDown, strobe.init}));

endmodule

// File: rtl/svp_datapath.sv
module svp_datapath #(
  parameter int DATA_W  = 32,
  parameter int PC_W    = 32,
  parameter int DEPTH   = 64,
  parameter int CNT_W   = 2,
  parameter int PC_LSB  = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [PC_W-1:0]       lkpPc,
  output logic [DATA_W-1:0]     lkpValue,
  output logic                  lkpConfident,
  input  logic [PC_W-1:0]       updPc,
  input  logic [DATA_W-1:0]     updValue,
  input  svp_pkg::svp_strobe_t  strobe,
  output logic                  entryValid,
  output logic                  predHit,
  output logic                  strideRepeat,
  output logic [CNT_W-1:0]      entryCnt
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [CNT_W-1:0] CONF_TH = CNT_W'(1) << (CNT_W - 1);

  logic [DATA_W-1:0] lastQ   [DEPTH];
  logic [DATA_W-1:0] recentQ [DEPTH];
  logic [DATA_W-1:0] stableQ [DEPTH];
  logic [CNT_W-1:0]  cntQ    [DEPTH];
  logic [DEPTH-1:0]  validQ;

  logic [IDX_W-1:0]  lkpIdx, updIdx;
  logic [DATA_W-1:0] newDiff, updPred;

  assign lkpIdx = lkpPc[PC_LSB +: IDX_W];
  assign updIdx = updPc[PC_LSB +: IDX_W];

  // Lookup side
  always_comb begin
    if (validQ[lkpIdx]) begin
      lkpValue     = lastQ[lkpIdx] + stableQ[lkpIdx];
      lkpConfident = (cntQ[lkpIdx] >= CONF_TH);
    end else begin
      lkpValue     = '0;
      lkpConfident = 1'b0;
    end
  end

  // Update side flags for control
  assign updPred      = lastQ[updIdx] + stableQ[updIdx];
  assign newDiff      = updValue - lastQ[updIdx];
  assign entryValid   = validQ[updIdx];
  assign predHit      = (updPred == updValue);
  assign strideRepeat = (newDiff == recentQ[updIdx]);
  assign entryCnt     = cntQ[updIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        lastQ[i]   <= '0;
        recentQ[i] <= '0;
        stableQ[i] <= '0;
        cntQ[i]    <= '0;
      end
    end else if (strobe.wrEn) begin
      lastQ[updIdx] <= updValue;
      if (strobe.init) begin
        validQ[updIdx]  <= 1'b1;
        recentQ[updIdx] <= '0;
        stableQ[updIdx] <= '0;
        cntQ[updIdx]    <= '0;
      end else begin
        recentQ[updIdx] <= newDiff;
        if (strobe.takeStride) stableQ[updIdx] <= newDiff;
        if (strobe.cntUp)      cntQ[updIdx] <= cntQ[updIdx] + 1'b1;
        else if (strobe.cntDown) cntQ[updIdx] <= cntQ[updIdx] - 1'b1;
      end
    end
  end

  // R2
  init_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.init |=> validQ[$past(updIdx)] && (cntQ[$past(updIdx)] == '0)
      && (stableQ[$past(updIdx)] == '0) && (lastQ[$past(updIdx)] == $past(updValue)));

  // R7
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && !strobe.init) |=>
      (cntQ[$past(updIdx)] - $past(cntQ[updIdx])) != CNT_W'(2));

  // R4
  stable_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && !strobe.init && !strobe.takeStride) |=>
      stableQ[$past(updIdx)] == $past(stableQ[updIdx]));

  // R1
  conf_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkpConfident |-> validQ[lkpIdx]);

endmodule

// File: rtl/stride_value_predictor.sv
module stride_value_predictor #(
  parameter int DATA_W = 32,
  parameter int PC_W   = 32,
  parameter int DEPTH  = 64,
  parameter int CNT_W  = 2,
  parameter int PC_LSB = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   lkpPc,
  output logic [DATA_W-1:0] lkpValue,
  output logic              lkpConfident,
  input  logic              updValid,
  input  logic [PC_W-1:0]   updPc,
  input  logic [DATA_W-1:0] updValue
);
  svp_pkg::svp_strobe_t strobe;
  logic             entryValid, predHit, strideRepeat;
  logic [CNT_W-1:0] entryCnt;

  svp_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .updValid(updValid), .entryValid(entryValid),
    .predHit(predHit), .strideRepeat(strideRepeat), .entryCnt(entryCnt),
    .strobe(strobe)
  );

  svp_datapath #(.DATA_W(DATA_W), .PC_W(PC_W), .DEPTH(DEPTH),
                 .CNT_W(CNT_W), .PC_LSB(PC_LSB)) u_dp (
    .clk(clk), .rstN(rstN), .lkpPc(lkpPc), .lkpValue(lkpValue),
    .lkpConfident(lkpConfident), .updPc(updPc), .updValue(updValue),
    .strobe(strobe), .entryValid(entryValid), .predHit(predHit),
    .strideRepeat(strideRepeat), .entryCnt(entryCnt)
  );

endmodule

// File: tb/stride_value_predictor_bench.sv
module stride_value_predictor_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] lkpPc = '0, updPc = '0, updValue = '0;
  logic        updValid = 1'b0;
  logic [31:0] lkpValue;
  logic        lkpConfident;

  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  stride_value_predictor u_stride_value_predictor (
    .clk(clk), .rstN(rstN), .lkpPc(lkpPc), .lkpValue(lkpValue),
    .lkpConfident(lkpConfident), .updValid(updValid), .updPc(updPc),
    .updValue(updValue)
  );

  // Reference model built from the requirements
  logic [31:0] mLast[64], mRecent[64], mStable[64];
  int unsigned mCnt[64];
  bit          mValid[64];

  function automatic int idxOf(logic [31:0] pc);
    return int'(pc[7:2]);
  endfunction

  function automatic logic [31:0] expValue(logic [31:0] pc);
    int i = idxOf(pc);
    return mValid[i] ? mLast[i] + mStable[i] : 32'd0;
  endfunction

  function automatic bit expConf(logic [31:0] pc);
    int i = idxOf(pc);
    return mValid[i] && (mCnt[i] >= 2);
  endfunction

  function automatic void modelUpdate(logic [31:0] pc, logic [31:0] v);
    int i = idxOf(pc);
    logic [31:0] d;
    if (!mValid[i]) begin
      mValid[i] = 1; mLast[i] = v; mRecent[i] = 0; mStable[i] = 0; mCnt[i] = 0;
    end else begin
      if (mLast[i] + mStable[i] == v) begin
        if (mCnt[i] < 3) mCnt[i]++;
      end else if (mCnt[i] > 0) mCnt[i]--;
      d = v - mLast[i];
      if (d == mRecent[i]) mStable[i] = d;
      mRecent[i] = d;
      mLast[i] = v;
    end
  endfunction

  task automatic checkLookup(string req);
    logic [31:0] ev = expValue(lkpPc);
    bit ec = expConf(lkpPc);
    total++;
    if (lkpValue !== ev || lkpConfident !== ec) begin
      bad++;
      $display("FAIL %s pc=%h value=%h conf=%0b expected value=%h conf=%0b",
               req, lkpPc, lkpValue, lkpConfident, ev, ec);
    end
  endtask

  // One cycle: drive at falling edge, check lookup (pre-update state, R9), clock.
  task automatic step(bit doUpd, logic [31:0] uPc, logic [31:0] uVal,
                      logic [31:0] lPc, string req);
    @(negedge clk);
    updValid = doUpd; updPc = uPc; updValue = uVal; lkpPc = lPc;
    #1;
    checkLookup(req);
    if (doUpd) modelUpdate(uPc, uVal);
    @(posedge clk);
  endtask

  task automatic feed(logic [31:0] pc, logic [31:0] v, string req);
    step(1, pc, v, pc, req);
    step(0, pc, 0, pc, req);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] pcs[8];
    logic [31:0] nextV[8], strd[8];
    int unsigned seedDummy;
    seedDummy = $urandom(32'd24601);
    for (int i = 0; i < 64; i++) begin
      mValid[i] = 0; mLast[i] = 0; mRecent[i] = 0; mStable[i] = 0; mCnt[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state, several addresses
    step(0, 0, 0, 32'h0000_0040, "R1");
    step(0, 0, 0, 32'h0000_00fc, "R1");

    // R2 / R5: constant sequence on 0x40, counter climbs to confident
    feed(32'h40, 32'd5, "R2");
    feed(32'h40, 32'd5, "R5");
    feed(32'h40, 32'd5, "R5");
    for (int k = 0; k < 4; k++) feed(32'h40, 32'd5, "R7 saturate");
    feed(32'h40, 32'd9, "R7 miss from saturation");
    feed(32'h40, 32'd12, "R4 one-off difference");

    // R6: strict stride on 0x80
    for (int k = 0; k < 6; k++) feed(32'h80, 32'd10 + 32'd3 * k, "R6");
    // R4: single outlier must not change the stable stride
    feed(32'h80, 32'd100, "R4 outlier");
    feed(32'h80, 32'd103, "R4 recover");

    // R6 wraparound stride of 1 across 2^32
    feed(32'hc0, 32'hffff_fffe, "R6 wrap");
    feed(32'hc0, 32'hffff_ffff, "R6 wrap");
    feed(32'hc0, 32'h0000_0000, "R6 wrap");
    feed(32'hc0, 32'h0000_0001, "R6 wrap");

    // R8: aliasing, 0x1080 shares entry with 0x80
    step(0, 0, 0, 32'h0000_1080, "R8 alias lookup");
    feed(32'h0000_1080, 32'd7, "R8 alias update");
    step(0, 0, 0, 32'h0000_0080, "R8 alias view");

    // R9: same-cycle lookup and update of one entry
    step(1, 32'hc0, 32'd2, 32'hc0, "R9");
    step(0, 0, 0, 32'hc0, "R9 next cycle");

    // Constrained random traffic
    for (int k = 0; k < 8; k++) begin
      pcs[k]   = 32'h2000 + 32'(k) * 4;
      nextV[k] = $urandom;
      strd[k]  = $urandom % 16;
    end
    pcs[7] = 32'h2100;  // aliases pcs[0] (R8)
    for (int n = 0; n < 4000; n++) begin
      int k = $urandom % 8;
      int l = $urandom % 8;
      bit u = ($urandom % 4) != 0;
      logic [31:0] v;
      if ($urandom % 24 == 0) strd[k] = $urandom % 32;
      v = nextV[k];
      if ($urandom % 20 == 0) v = $urandom;
      nextV[k] = nextV[k] + strd[k];
      step(u, pcs[k], v, pcs[l], "R3 R4 R7 random");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule